// File: doc/BRIEF.md
# Priority Nesting Interrupt Controller

This block gathers 32 interrupt request lines on behalf of a small processor core. Each line has a fixed priority: line 0 ranks highest and line 31 lowest. The block keeps a pending vector. It chooses the best request that is allowed to run and, at an instruction boundary, hands the core the interrupt number and the address of the table entry that holds the handler.

An in-service vector records every level whose handler has started and not yet returned. The lowest-numbered set bit gives the priority of the running handler. A new request gets through only if it ranks strictly higher than that handler.

Lines 0 to 7 are non-maskable. Lines 8 to 31 also need the core's interrupt-enable flag. The block does not touch memory itself. Instead it outputs, one code per cycle, the steps the core must carry out on the stack when a handler is entered or left.

Some lines are external pins, sampled every cycle. The rest are single-cycle internal events, such as timer matches, overflow, division by zero, invalid opcode and breakpoint. An event stays latched until its interrupt is acknowledged.

Top module: `prio_irq_ctrl`

## Requirements
- R1: When several requests are eligible in the same cycle, the lowest-numbered one is taken.
- R2: Lines 0 to 7 are taken whatever the value of `ie_flag`, and they preempt any running handler of a higher-numbered line.
- R3: Lines 8 to 31 are taken only while `ie_flag` is 1, even when they outrank the running handler.
- R4: A request whose number is equal to or greater than the lowest-numbered in-service bit is held back until that level is released.
- R5: Lines 0 and 1 are pins that request when high. Lines 9, 11, 13 and 16 to 31 are pins that request when low. Pins are sampled every cycle and are not latched, so a pulse that goes away before a boundary is lost. Bits of `pin_raw` at event positions are ignored.
- R6: Lines 2 to 8, 10, 12, 14 and 15 are events. A one-cycle pulse on `evt_in` stays pending until that line is acknowledged, and is then cleared. Bits of `evt_in` at pin positions are ignored.
- R7: An interrupt is taken only in a cycle where `insn_done` is 1. `irq_take` pulses for one cycle in the following cycle, and at the same time `irq_num` is valid.
- R8: `vec_addr` equals `table_base + 2*irq_num` for the interrupt taken.
- R9: When an interrupt is taken, its bit in `in_service` is set at the same edge that raises `irq_take`.
- R10: Starting with the `irq_take` cycle, `stack_step` runs through 1 (decrement SP), 2 (store flags), 3 (decrement SP), 4 (store IP) and 5 (fetch vector), then returns to 0 (idle). No interrupt is taken while `stack_step` is not 0.
- R11: An `iret` pulse is accepted when `stack_step` is 0 and `in_service` is not zero; otherwise it is ignored. Acceptance clears the lowest-numbered `in_service` bit at the next edge. `stack_step` then runs through 6 (load IP), 7 (increment SP), 8 (load flags) and 9 (increment SP), then returns to 0.
- R12: After reset, `irq_take`, `irq_num`, `vec_addr`, `in_service` and `stack_step` are all zero, and nothing is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pin_raw | input | 32 | Raw pin levels; polarity per line |
| evt_in | input | 32 | One-cycle internal event pulses |
| ie_flag | input | 1 | Interrupt-enable flag from the core |
| insn_done | input | 1 | Current instruction completes this cycle |
| iret | input | 1 | Core executes an interrupt return |
| table_base | input | 32 | Base address of the handler table |
| irq_take | output | 1 | One-cycle pulse: interrupt accepted |
| irq_num | output | 5 | Number of the accepted interrupt |
| vec_addr | output | 32 | Address of the handler table entry |
| in_service | output | 32 | One bit per level whose handler is active |
| stack_step | output | 4 | Current stack step code for the core |

## Verification
The assertions check the following on every cycle:
- each take follows a boundary cycle and an idle sequencer;
- a maskable take is backed by the enable flag;
- the vector address matches the number;
- a take becomes the highest-ranked in-service level;
- both stack sequences run in order;
- an accepted return removes exactly one in-service bit.

Other behaviours can only be shown by the bench's scenarios:
- that the correct winner is chosen among mixed pin and event requests;
- that pin polarity is applied;
- that a pin pulse is lost while an event pulse is kept;
- that held-back requests are taken once the enable flag rises;
- that nested handlers are released lowest-numbered first.

// File: rtl/irq_pkg.sv
package irq_pkg;
  typedef enum logic [3:0] {
    STP_IDLE      = 4'd0,
    STP_ENT_DEC1  = 4'd1,
    STP_ENT_FLAGS = 4'd2,
    STP_ENT_DEC2  = 4'd3,
    STP_ENT_IP    = 4'd4,
    STP_ENT_VEC   = 4'd5,
    STP_RET_IP    = 4'd6,
    STP_RET_INC1  = 4'd7,
    STP_RET_FLAGS = 4'd8,
    STP_RET_INC2  = 4'd9
  } stk_step_e;
endpackage

// File: rtl/irq_pend.sv
module irq_pend #(
  parameter int N = 32,
  parameter logic [N-1:0] LEVEL_MASK = '0,
  parameter logic [N-1:0] LOW_MASK = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] pin_raw,
  input  logic [N-1:0] evt_in,
  input  logic [N-1:0] ack_oh,
  output logic [N-1:0] pend
);
  for (genvar i = 0; i < N; i++) begin : g_line
    if (LEVEL_MASK[i]) begin : g_pin
      always_ff @(posedge clk) begin
        if (rst) pend[i] <= 1'b0;
        else     pend[i] <= pin_raw[i] ^ LOW_MASK[i];
      end
    end else begin : g_evt
      always_ff @(posedge clk) begin
        if (rst) pend[i] <= 1'b0;
        else     pend[i] <= (pend[i] & ~ack_oh[i]) | evt_in[i];
      end
    end
  end
endmodule

// File: rtl/irq_arb.sv
module irq_arb #(
  parameter int N = 32,
  parameter int NUM_NMI = 8,
  localparam int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]   pend,
  input  logic [IDX_W:0] cur_lvl,
  input  logic           ie,
  output logic           valid,
  output logic [IDX_W-1:0] idx
);
  logic [N-1:0] elig;

  for (genvar i = 0; i < N; i++) begin : g_elig
    if (i < NUM_NMI) begin : g_nmi
      assign elig[i] = pend[i] && (cur_lvl > (IDX_W+1)'(i));
    end else begin : g_mask
      assign elig[i] = pend[i] && ie && (cur_lvl > (IDX_W+1)'(i));
    end
  end

  always_comb begin
    valid = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (elig[i]) begin
        valid = 1'b1;
        idx   = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/irq_isr.sv
module irq_isr #(
  parameter int N = 32,
  localparam int IDX_W = $clog2(N)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             set_en,
  input  logic [IDX_W-1:0] set_idx,
  input  logic             clr_en,
  output logic [N-1:0]     isr,
  output logic [IDX_W:0]   cur_lvl
);
  always_ff @(posedge clk) begin
    if (rst)         isr <= '0;
    else if (clr_en) isr <= isr & (isr - N'(1));
    else if (set_en) isr <= isr | (N'(1) << set_idx);
  end

  always_comb begin
    cur_lvl = (IDX_W+1)'(N);
    for (int i = N - 1; i >= 0; i--) begin
      if (isr[i]) cur_lvl = (IDX_W+1)'(i);
    end
  end
endmodule

// File: rtl/irq_seq.sv
module irq_seq
  import irq_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      start_ent,
  input  logic      start_ret,
  output stk_step_e step,
  output logic      idle
);
  stk_step_e nxt;

  always_comb begin
    case (step)
      STP_IDLE:      nxt = start_ret ? STP_RET_IP : (start_ent ? STP_ENT_DEC1 : STP_IDLE);
      STP_ENT_DEC1:  nxt = STP_ENT_FLAGS;
      STP_ENT_FLAGS: nxt = STP_ENT_DEC2;
      STP_ENT_DEC2:  nxt = STP_ENT_IP;
      STP_ENT_IP:    nxt = STP_ENT_VEC;
      STP_RET_IP:    nxt = STP_RET_INC1;
      STP_RET_INC1:  nxt = STP_RET_FLAGS;
      STP_RET_FLAGS: nxt = STP_RET_INC2;
      default:       nxt = STP_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) step <= STP_IDLE;
    else     step <= nxt;
  end

  assign idle = (step == STP_IDLE);
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import irq_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter int NUM_NMI = 8,
  parameter int ADDR_W = 32,
  parameter logic [NUM_SRC-1:0] LEVEL_MASK = 32'hFFFF_2A03,
  parameter logic [NUM_SRC-1:0] LOW_MASK = 32'hFFFF_2A00,
  localparam int IDX_W = $clog2(NUM_SRC)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] pin_raw,
  input  logic [NUM_SRC-1:0] evt_in,
  input  logic               ie_flag,
  input  logic               insn_done,
  input  logic               iret,
  input  logic [ADDR_W-1:0]  table_base,
  output logic               irq_take,
  output logic [IDX_W-1:0]   irq_num,
  output logic [ADDR_W-1:0]  vec_addr,
  output logic [NUM_SRC-1:0] in_service,
  output logic [3:0]         stack_step
);
  logic [NUM_SRC-1:0] pend;
  logic [NUM_SRC-1:0] ack_oh;
  logic [IDX_W:0]     cur_lvl;
  logic               win_valid;
  logic [IDX_W-1:0]   win_idx;
  logic               seq_idle;
  logic               take_now;
  logic               ret_now;
  stk_step_e          step;

  assign ret_now  = iret && seq_idle && (|in_service);
  assign take_now = insn_done && seq_idle && !ret_now && win_valid;
  assign ack_oh   = take_now ? (NUM_SRC'(1) << win_idx) : '0;

  irq_pend #(.N(NUM_SRC), .LEVEL_MASK(LEVEL_MASK), .LOW_MASK(LOW_MASK)) u_pend (
    .clk(clk), .rst(rst), .pin_raw(pin_raw), .evt_in(evt_in),
    .ack_oh(ack_oh), .pend(pend)
  );

  irq_arb #(.N(NUM_SRC), .NUM_NMI(NUM_NMI)) u_arb (
    .pend(pend), .cur_lvl(cur_lvl), .ie(ie_flag),
    .valid(win_valid), .idx(win_idx)
  );

  irq_isr #(.N(NUM_SRC)) u_isr (
    .clk(clk), .rst(rst), .set_en(take_now), .set_idx(win_idx),
    .clr_en(ret_now), .isr(in_service), .cur_lvl(cur_lvl)
  );

  irq_seq u_seq (
    .clk(clk), .rst(rst), .start_ent(take_now), .start_ret(ret_now),
    .step(step), .idle(seq_idle)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_take <= 1'b0;
      irq_num  <= '0;
      vec_addr <= '0;
    end else begin
      irq_take <= take_now;
      if (take_now) begin
        irq_num  <= win_idx;
        vec_addr <= table_base + ADDR_W'({win_idx, 1'b0});
      end
    end
  end

  assign stack_step = step;
endmodule

// File: rtl/irq_chk.sv
module irq_chk #(
  parameter int NUM_SRC = 32,
  parameter int NUM_NMI = 8,
  parameter int ADDR_W = 32,
  localparam int IDX_W = $clog2(NUM_SRC)
) (
  input logic               clk,
  input logic               rst,
  input logic               ie_flag,
  input logic               insn_done,
  input logic               iret,
  input logic [ADDR_W-1:0]  table_base,
  input logic               irq_take,
  input logic [IDX_W-1:0]   irq_num,
  input logic [ADDR_W-1:0]  vec_addr,
  input logic [NUM_SRC-1:0] in_service,
  input logic [3:0]         stack_step
);
  p_take_boundary_r7: assert property (@(posedge clk) disable iff (rst)
    irq_take |-> $past(insn_done));

  p_take_idle_r10: assert property (@(posedge clk) disable iff (rst)
    irq_take |-> $past(stack_step) == 4'd0);

  p_mask_gate_r3: assert property (@(posedge clk) disable iff (rst)
    (irq_take && (int'(irq_num) >= NUM_NMI)) |-> $past(ie_flag));

  p_vec_addr_r8: assert property (@(posedge clk) disable iff (rst)
    irq_take |-> vec_addr == $past(table_base) + ADDR_W'({irq_num, 1'b0}));

  p_isr_set_r9: assert property (@(posedge clk) disable iff (rst)
    irq_take |-> in_service[irq_num]);

  p_nest_top_r4: assert property (@(posedge clk) disable iff (rst)
    irq_take |-> (in_service & ((NUM_SRC'(1) << irq_num) - NUM_SRC'(1))) == '0);

  p_ent_a_r10: assert property (@(posedge clk) disable iff (rst)
    stack_step == 4'd1 |=> stack_step == 4'd2);
  p_ent_b_r10: assert property (@(posedge clk) disable iff (rst)
    stack_step == 4'd2 |=> stack_step == 4'd3);
  p_ent_c_r10: assert property (@(posedge clk) disable iff (rst)
    stack_step == 4'd3 |=> stack_step == 4'd4);
  p_ent_d_r10: assert property (@(posedge clk) disable iff (rst)
    stack_step == 4'd4 |=> stack_step == 4'd5);
  p_ent_e_r10: assert property (@(posedge clk) disable iff (rst)
    stack_step == 4'd5 |=> stack_step == 4'd0);

  p_ret_a_r11: assert property (@(posedge clk) disable iff (rst)
    stack_step == 4'd6 |=> stack_step == 4'd7);
  p_ret_b_r11: assert property (@(posedge clk) disable iff (rst)
    stack_step == 4'd7 |=> stack_step == 4'd8);
  p_ret_c_r11: assert property (@(posedge clk) disable iff (rst)
    stack_step == 4'd8 |=> stack_step == 4'd9);
  p_ret_d_r11: assert property (@(posedge clk) disable iff (rst)
    stack_step == 4'd9 |=> stack_step == 4'd0);

  p_ret_clear_r11: assert property (@(posedge clk) disable iff (rst)
    (iret && stack_step == 4'd0 && (|in_service)) |=>
      ($countones(in_service) == $countones($past(in_service)) - 1) && stack_step == 4'd6);
endmodule

bind prio_irq_ctrl irq_chk #(.NUM_SRC(NUM_SRC), .NUM_NMI(NUM_NMI), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .ie_flag(ie_flag), .insn_done(insn_done), .iret(iret),
  .table_base(table_base), .irq_take(irq_take), .irq_num(irq_num),
  .vec_addr(vec_addr), .in_service(in_service), .stack_step(stack_step)
);

// File: tb/prio_irq_ctrl_tb.sv
module prio_irq_ctrl_tb;
  localparam logic [31:0] LOW_MASK = 32'hFFFF_2A00;
  localparam logic [31:0] BASE = 32'h0001_2340;
  localparam int NV = 9;

  // Walked table: logical pin activity, event pulses, enable, expected take/number
  localparam logic [31:0] V_PIN [NV] = '{
    32'h0000_0001,   // R2: line 0 with enable clear
    32'h0001_0000,   // R3: line 16, enable clear
    32'h0001_0000,   // R3/R5: line 16, enable set (active low pin)
    32'h8000_0000,   // R1: line 31 pin vs line 10 event
    32'h0000_0002,   // R1/R5: line 1 pin vs line 2 event
    32'h0000_0000,   // R3: line 8 event, enable clear
    32'h0000_0000,   // R2: line 4 event, enable clear
    32'h0000_2200,   // R1: lines 9 and 13
    32'h0000_0008    // R5/R6: wrong-kind inputs only
  };
  localparam logic [31:0] V_EVT [NV] = '{
    32'h0, 32'h0, 32'h0, 32'h0000_0400, 32'h0000_0004,
    32'h0000_0100, 32'h0000_0010, 32'h0, 32'h0000_0200
  };
  localparam logic V_IE   [NV] = '{1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1};
  localparam logic V_TAKE [NV] = '{1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0};
  localparam logic [4:0] V_NUM [NV] = '{5'd0, 5'd0, 5'd16, 5'd10, 5'd1, 5'd0, 5'd4, 5'd9, 5'd0};

  logic        clk = 1'b0;
  logic        rst;
  logic [31:0] pin_raw, evt_in, table_base;
  logic        ie_flag, insn_done, iret;
  logic        irq_take;
  logic [4:0]  irq_num;
  logic [31:0] vec_addr, in_service;
  logic [3:0]  stack_step;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  always #5 clk = ~clk;

  prio_irq_ctrl u_dut (
    .clk(clk), .rst(rst), .pin_raw(pin_raw), .evt_in(evt_in), .ie_flag(ie_flag),
    .insn_done(insn_done), .iret(iret), .table_base(table_base),
    .irq_take(irq_take), .irq_num(irq_num), .vec_addr(vec_addr),
    .in_service(in_service), .stack_step(stack_step)
  );

  function automatic logic [31:0] raw(input logic [31:0] act);
    return act ^ LOW_MASK;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset;
    rst = 1'b1; pin_raw = raw(32'h0); evt_in = '0; ie_flag = 1'b0;
    insn_done = 1'b0; iret = 1'b0; table_base = BASE;
    step_n(2);
    rst = 1'b0;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 50000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    do_reset;
    // R12: reset state
    chk("R12 take", {31'h0, irq_take}, 32'h0);
    chk("R12 num", {27'h0, irq_num}, 32'h0);
    chk("R12 vec", vec_addr, 32'h0);
    chk("R12 isr", in_service, 32'h0);
    chk("R12 step", {28'h0, stack_step}, 32'h0);
    // R11: iret with nothing in service is ignored
    iret = 1'b1; step_n(1); iret = 1'b0;
    chk("R11 idle iret", {28'h0, stack_step}, 32'h0);

    for (int v = 0; v < NV; v++) begin
      do_reset;
      pin_raw = raw(V_PIN[v]); evt_in = V_EVT[v]; ie_flag = V_IE[v];
      step_n(1);
      evt_in = '0; insn_done = 1'b1;
      step_n(1);
      insn_done = 1'b0;
      chk("R7 take per vector", {31'h0, irq_take}, {31'h0, V_TAKE[v]});
      if (V_TAKE[v]) begin
        chk("R1 winner", {27'h0, irq_num}, {27'h0, V_NUM[v]});
        chk("R8 vec addr", vec_addr, BASE + 32'(V_NUM[v]) * 2);
      end
      pin_raw = raw(32'h0);
      step_n(8);
    end

    // Nesting, busy lockout, stack sequences
    do_reset;
    ie_flag = 1'b1; pin_raw = raw(32'h0010_0000);
    step_n(1); insn_done = 1'b1;
    step_n(1);
    chk("R1 take 20", {27'h0, irq_num}, 32'd20);
    chk("R10 step1", {28'h0, stack_step}, 32'd1);
    evt_in = 32'h0000_0008;
    step_n(1); evt_in = '0;
    chk("R10 busy take", {31'h0, irq_take}, 32'h0);
    chk("R10 step2", {28'h0, stack_step}, 32'd2);
    for (int k = 3; k <= 5; k++) begin
      step_n(1);
      chk("R10 step seq", {28'h0, stack_step}, 32'(k));
      chk("R10 busy take", {31'h0, irq_take}, 32'h0);
    end
    step_n(1);
    chk("R10 back idle", {28'h0, stack_step}, 32'd0);
    chk("R10 busy take", {31'h0, irq_take}, 32'h0);
    step_n(1);
    chk("R2 preempt take", {31'h0, irq_take}, 32'h1);
    chk("R2 preempt num", {27'h0, irq_num}, 32'd3);
    chk("R9 isr nested", in_service, 32'h0010_0008);
    insn_done = 1'b0;
    step_n(6);
    iret = 1'b1; step_n(1); iret = 1'b0;
    chk("R11 ret step6", {28'h0, stack_step}, 32'd6);
    chk("R11 clear lowest", in_service, 32'h0010_0000);
    for (int k = 7; k <= 9; k++) begin
      step_n(1);
      chk("R11 ret seq", {28'h0, stack_step}, 32'(k));
    end
    step_n(1);
    chk("R11 ret idle", {28'h0, stack_step}, 32'd0);
    // R4: equal and lower lines wait
    pin_raw = raw(32'h0210_0000); insn_done = 1'b1;
    for (int k = 0; k < 3; k++) begin
      step_n(1);
      chk("R4 held", {31'h0, irq_take}, 32'h0);
    end
    // R3: higher maskable line blocked while enable clear
    ie_flag = 1'b0; pin_raw = raw(32'h0211_0000);
    for (int k = 0; k < 3; k++) begin
      step_n(1);
      chk("R3 masked", {31'h0, irq_take}, 32'h0);
    end
    ie_flag = 1'b1;
    step_n(1);
    chk("R3 enabled take", {31'h0, irq_take}, 32'h1);
    chk("R3 enabled num", {27'h0, irq_num}, 32'd16);
    chk("R9 isr 16+20", in_service, 32'h0011_0000);
    insn_done = 1'b0; pin_raw = raw(32'h0);
    step_n(6);
    iret = 1'b1; step_n(1); iret = 1'b0;
    chk("R11 release 16", in_service, 32'h0010_0000);
    step_n(5);
    iret = 1'b1; step_n(1); iret = 1'b0;
    chk("R11 release 20", in_service, 32'h0);
    step_n(5);

    // R6: event held pending until acknowledged
    do_reset;
    evt_in = 32'h0000_1000;
    step_n(1); evt_in = '0; insn_done = 1'b1;
    for (int k = 0; k < 4; k++) begin
      step_n(1);
      chk("R3 event masked", {31'h0, irq_take}, 32'h0);
    end
    ie_flag = 1'b1;
    step_n(1);
    chk("R6 held event take", {31'h0, irq_take}, 32'h1);
    chk("R6 held event num", {27'h0, irq_num}, 32'd12);
    insn_done = 1'b0;
    step_n(6);
    iret = 1'b1; step_n(1); iret = 1'b0;
    step_n(5);
    insn_done = 1'b1;
    for (int k = 0; k < 3; k++) begin
      step_n(1);
      chk("R6 cleared on ack", {31'h0, irq_take}, 32'h0);
    end
    insn_done = 1'b0;

    // R5: a pin pulse that vanishes is not latched
    do_reset;
    ie_flag = 1'b1; pin_raw = raw(32'h0001_0000);
    step_n(3);
    pin_raw = raw(32'h0);
    step_n(2);
    insn_done = 1'b1;
    for (int k = 0; k < 3; k++) begin
      step_n(1);
      chk("R5 pin not latched", {31'h0, irq_take}, 32'h0);
    end
    insn_done = 1'b0;

    // R7: pending line waits for the boundary
    do_reset;
    pin_raw = raw(32'h0000_0001);
    for (int k = 0; k < 4; k++) begin
      step_n(1);
      chk("R7 no boundary", {31'h0, irq_take}, 32'h0);
    end
    insn_done = 1'b1;
    step_n(1);
    insn_done = 1'b0;
    chk("R7 boundary take", {31'h0, irq_take}, 32'h1);
    step_n(1);
    chk("R7 single pulse", {31'h0, irq_take}, 32'h0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule